// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block produces the instruction address for a small 4-bit controller. Each instruction cycle it either steps to the next word, skips one word, or loads a 13-bit absolute target. Calls and interrupt entries save a return frame on an eight-entry hardware stack. Returns take the frame back off the stack. A frame saved by an interrupt entry also holds the data bank selector and the carry flag, and only a return-from-interrupt restores those two values. A plain return restores the address alone.

The decoder of the surrounding core presents a 3-bit operation code and a target address every cycle. The interrupt controller raises a one-cycle entry strobe, and the core's bank and carry registers feed their current values in. Either an external reset or a power-on indication restarts execution at address 0 and empties the stack. Two sticky flags report stack misuse: one for a push into a full stack and one for a pop from an empty stack.

Top module: `prog_sequencer`

## Requirements
- R1: While `rstN` is low or `porFlag` is high, the next clock edge sets `pc` to 0, empties the stack, and clears `bankOut`, `carryOut`, `stackOverflow` and `stackUnderflow`.
- R2: Operation code 000 (step) and the unused codes 110 and 111 set `pc` to `pc`+1 modulo 2^13, so 8191 is followed by 0.
- R3: Operation code 001 (skip) sets `pc` to `pc`+2 modulo 2^13.
- R4: Operation code 010 (jump) loads `targetAddr` into `pc` and leaves the stack unchanged.
- R5: Operation code 011 (call) pushes `pc`+1 and loads `targetAddr` into `pc`.
- R6: Operation code 100 (return) on a non-empty stack pops the newest frame into `pc`. `bankOut` and `carryOut` keep their values.
- R7: Operation code 101 (interrupt return) on a non-empty stack pops the newest frame into `pc`, `bankOut` and `carryOut`.
- R8: A high `intEnter` overrides the operation code. It pushes a frame holding the current `pc`, `bankIn` and `carryIn`, and sets `pc` to the parameter `INT_VECTOR` (default 4).
- R9: Frames come back in last-in first-out order for up to eight levels of nesting.
- R10: A push while eight frames are held sets `stackOverflow` and overwrites the oldest frame. The held count stays at eight, so the eight newest frames are still returned in order.
- R11: A return or interrupt return with an empty stack sets `stackUnderflow` and advances `pc` by 1. It leaves `bankOut` and `carryOut` unchanged.
- R12: Once set, `stackOverflow` and `stackUnderflow` stay high until a reset under R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rstN | input | 1 | External reset, active low, synchronous |
| porFlag | input | 1 | Power-on indication, active high, synchronous |
| opCode | input | 3 | Decoded sequencing operation |
| targetAddr | input | 13 | Absolute target for jump and call |
| intEnter | input | 1 | Interrupt entry strobe |
| bankIn | input | 2 | Current data bank selector |
| carryIn | input | 1 | Current carry flag |
| pc | output | 13 | Program counter |
| bankOut | output | 2 | Bank selector restored by interrupt return |
| carryOut | output | 1 | Carry flag restored by interrupt return |
| stackOverflow | output | 1 | Sticky push-into-full flag |
| stackUnderflow | output | 1 | Sticky pop-from-empty flag |

## Verification
The bench builds the block with its default parameters: a 13-bit address, a 2-bit bank, eight stack levels and an interrupt vector of 4. With eight levels, a nine-deep call chain is short enough to reach overflow and overwrite the oldest frame, and then to drain the stack into underflow. With a 13-bit address, a single jump to 8191 brings the wrap of both step and skip within reach. The interrupt vector of 4 is distinct from every call target, so a return frame that is wrong shows up in the address.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [2:0] {
    OP_STEP = 3'b000,
    OP_SKIP = 3'b001,
    OP_JUMP = 3'b010,
    OP_CALL = 3'b011,
    OP_RET  = 3'b100,
    OP_RETI = 3'b101
  } seqOp_e;

  typedef enum logic [2:0] {
    PC_INC1,
    PC_INC2,
    PC_TARGET,
    PC_VECTOR,
    PC_STACK
  } pcSel_e;

  // Strobes from control to datapath for one instruction cycle
  typedef struct packed {
    logic   push;         // write a frame at the free slot
    logic   pop;          // remove the newest frame
    logic   pushCurrent;  // frame address is pc (interrupt) rather than pc+1 (call)
    logic   restoreFrame; // load bank and carry from the popped frame
    pcSel_e pcSel;
  } seqStrobe_t;

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rstNow,
  input  logic [2:0] opCode,
  input  logic       intEnter,
  output seqStrobe_t strobe,
  output logic       stackOverflow,
  output logic       stackUnderflow
);

  logic [CNT_W-1:0] heldCount;
  logic             stackEmpty;
  logic             stackFull;
  logic             wantPush;
  logic             wantPop;
  logic             isRet;
  logic             isReti;

  assign stackEmpty = (heldCount == '0);
  assign stackFull  = (heldCount == CNT_W'(DEPTH));
  assign isRet      = (opCode == OP_RET);
  assign isReti     = (opCode == OP_RETI);
  assign wantPush   = intEnter || (opCode == OP_CALL);
  assign wantPop    = !intEnter && (isRet || isReti);

  always_comb begin
    strobe              = '0;
    strobe.pcSel        = PC_INC1;
    strobe.push         = wantPush;
    strobe.pushCurrent  = intEnter;
    strobe.pop          = wantPop && !stackEmpty;
    strobe.restoreFrame = wantPop && !stackEmpty && isReti;
    if (intEnter) begin
      strobe.pcSel = PC_VECTOR;
    end else begin
      unique case (opCode)
        OP_SKIP:         strobe.pcSel = PC_INC2;
        OP_JUMP,
        OP_CALL:         strobe.pcSel = PC_TARGET;
        OP_RET, OP_RETI: strobe.pcSel = stackEmpty ? PC_INC1 : PC_STACK;
        default:         strobe.pcSel = PC_INC1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rstNow) begin
      heldCount      <= '0;
      stackOverflow  <= 1'b0;
      stackUnderflow <= 1'b0;
    end else begin
      if (wantPush) begin
        if (stackFull) stackOverflow <= 1'b1;
        else           heldCount     <= heldCount + CNT_W'(1);
      end else if (wantPop) begin
        if (stackEmpty) stackUnderflow <= 1'b1;
        else            heldCount      <= heldCount - CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BANK_W = 2,
  parameter int DEPTH  = 8,
  parameter logic [ADDR_W-1:0] INT_VECTOR = 'd4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstNow,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] targetAddr,
  input  logic [BANK_W-1:0] bankIn,
  input  logic              carryIn,
  output logic [ADDR_W-1:0] pc,
  output logic [BANK_W-1:0] bankOut,
  output logic              carryOut
);

  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] entryPc    [DEPTH];
  logic [BANK_W-1:0] entryBank  [DEPTH];
  logic              entryCarry [DEPTH];

  logic [PTR_W-1:0]  freeSlot;
  logic [PTR_W-1:0]  topSlot;
  logic [PTR_W-1:0]  afterSlot;
  logic [ADDR_W-1:0] pcPlusOne;
  logic [ADDR_W-1:0] pcPlusTwo;
  logic [ADDR_W-1:0] pushAddr;
  logic [ADDR_W-1:0] pcNext;

  assign topSlot   = (freeSlot == '0) ? LAST_SLOT : freeSlot - PTR_W'(1);
  assign afterSlot = (freeSlot == LAST_SLOT) ? '0 : freeSlot + PTR_W'(1);
  assign pcPlusOne = pc + ADDR_W'(1);
  assign pcPlusTwo = pc + ADDR_W'(2);
  assign pushAddr  = strobe.pushCurrent ? pc : pcPlusOne;

  always_comb begin
    unique case (strobe.pcSel)
      PC_INC2:   pcNext = pcPlusTwo;
      PC_TARGET: pcNext = targetAddr;
      PC_VECTOR: pcNext = INT_VECTOR;
      PC_STACK:  pcNext = entryPc[topSlot];
      default:   pcNext = pcPlusOne;
    endcase
  end

  // Frame storage: overwrites wrap onto the oldest slot
  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      if (!rstNow && strobe.push && (freeSlot == PTR_W'(e))) begin
        entryPc[e]    <= pushAddr;
        entryBank[e]  <= bankIn;
        entryCarry[e] <= carryIn;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rstNow) begin
      pc       <= '0;
      freeSlot <= '0;
      bankOut  <= '0;
      carryOut <= 1'b0;
    end else begin
      pc <= pcNext;
      if (strobe.push)     freeSlot <= afterSlot;
      else if (strobe.pop) freeSlot <= topSlot;
      if (strobe.restoreFrame) begin
        bankOut  <= entryBank[topSlot];
        carryOut <= entryCarry[topSlot];
      end
    end
  end

endmodule

// File: rtl/prog_sequencer.sv
module prog_sequencer
  import seq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BANK_W = 2,
  parameter int DEPTH  = 8,
  parameter logic [ADDR_W-1:0] INT_VECTOR = 'd4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porFlag,
  input  logic [2:0]        opCode,
  input  logic [ADDR_W-1:0] targetAddr,
  input  logic              intEnter,
  input  logic [BANK_W-1:0] bankIn,
  input  logic              carryIn,
  output logic [ADDR_W-1:0] pc,
  output logic [BANK_W-1:0] bankOut,
  output logic              carryOut,
  output logic              stackOverflow,
  output logic              stackUnderflow
);

  logic       rstNow;
  seqStrobe_t strobe;

  assign rstNow = !rstN || porFlag;

  seq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk           (clk),
    .rstNow        (rstNow),
    .opCode        (opCode),
    .intEnter      (intEnter),
    .strobe        (strobe),
    .stackOverflow (stackOverflow),
    .stackUnderflow(stackUnderflow)
  );

  seq_datapath #(
    .ADDR_W    (ADDR_W),
    .BANK_W    (BANK_W),
    .DEPTH     (DEPTH),
    .INT_VECTOR(INT_VECTOR)
  ) u_dp (
    .clk       (clk),
    .rstNow    (rstNow),
    .strobe    (strobe),
    .targetAddr(targetAddr),
    .bankIn    (bankIn),
    .carryIn   (carryIn),
    .pc        (pc),
    .bankOut   (bankOut),
    .carryOut  (carryOut)
  );

endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int ADDR_W = 13,
  parameter int BANK_W = 2,
  parameter logic [ADDR_W-1:0] INT_VECTOR = 'd4
) (
  input logic              clk,
  input logic              rstN,
  input logic              porFlag,
  input logic [2:0]        opCode,
  input logic [ADDR_W-1:0] targetAddr,
  input logic              intEnter,
  input logic [ADDR_W-1:0] pc,
  input logic [BANK_W-1:0] bankOut,
  input logic              carryOut,
  input logic              stackOverflow,
  input logic              stackUnderflow
);

  logic rstAny;
  logic prevRst = 1'b0;

  assign rstAny = !rstN || porFlag;

  always_ff @(posedge clk) begin
    prevRst <= rstAny;
    if (prevRst) begin
      assert_reset_state_R1: assert (pc == '0 && bankOut == '0 && !carryOut
                                     && !stackOverflow && !stackUnderflow)
        else $error("reset state not reached");
    end
  end

  assert_step_R2: assert property (@(posedge clk) disable iff (rstAny)
    (!intEnter && (opCode == 3'b000 || opCode[2:1] == 2'b11))
      |=> pc == ADDR_W'($past(pc) + ADDR_W'(1)));

  assert_skip_R3: assert property (@(posedge clk) disable iff (rstAny)
    (!intEnter && opCode == 3'b001) |=> pc == ADDR_W'($past(pc) + ADDR_W'(2)));

  assert_jump_R4: assert property (@(posedge clk) disable iff (rstAny)
    (!intEnter && opCode == 3'b010) |=> pc == $past(targetAddr));

  assert_call_R5: assert property (@(posedge clk) disable iff (rstAny)
    (!intEnter && opCode == 3'b011) |=> pc == $past(targetAddr));

  assert_ret_keeps_flags_R6: assert property (@(posedge clk) disable iff (rstAny)
    (!intEnter && opCode == 3'b100) |=> ($stable(bankOut) && $stable(carryOut)));

  assert_vector_R8: assert property (@(posedge clk) disable iff (rstAny)
    intEnter |=> pc == INT_VECTOR);

  assert_no_overflow_drop_R12: assert property (@(posedge clk) disable iff (rstAny)
    stackOverflow |=> stackOverflow);

  assert_no_underflow_drop_R12: assert property (@(posedge clk) disable iff (rstAny)
    stackUnderflow |=> stackUnderflow);

endmodule

bind prog_sequencer seq_checker #(
  .ADDR_W    (ADDR_W),
  .BANK_W    (BANK_W),
  .INT_VECTOR(INT_VECTOR)
) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .porFlag       (porFlag),
  .opCode        (opCode),
  .targetAddr    (targetAddr),
  .intEnter      (intEnter),
  .pc            (pc),
  .bankOut       (bankOut),
  .carryOut      (carryOut),
  .stackOverflow (stackOverflow),
  .stackUnderflow(stackUnderflow)
);

// File: tb/prog_sequencer_tb.sv
module prog_sequencer_tb;

  localparam int ADDR_W = 13;
  localparam int BANK_W = 2;
  localparam int DEPTH  = 8;
  localparam logic [ADDR_W-1:0] VEC = 13'd4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              porFlag = 1'b0;
  logic [2:0]        opCode = 3'b000;
  logic [ADDR_W-1:0] targetAddr = '0;
  logic              intEnter = 1'b0;
  logic [BANK_W-1:0] bankIn = '0;
  logic              carryIn = 1'b0;
  logic [ADDR_W-1:0] pc;
  logic [BANK_W-1:0] bankOut;
  logic              carryOut;
  logic              stackOverflow;
  logic              stackUnderflow;

  always #4 clk = ~clk;

  prog_sequencer u_dut (
    .clk(clk), .rstN(rstN), .porFlag(porFlag), .opCode(opCode),
    .targetAddr(targetAddr), .intEnter(intEnter), .bankIn(bankIn),
    .carryIn(carryIn), .pc(pc), .bankOut(bankOut), .carryOut(carryOut),
    .stackOverflow(stackOverflow), .stackUnderflow(stackUnderflow)
  );

  // Reference state built from the requirements
  logic [ADDR_W-1:0] mPc = '0;
  logic [BANK_W-1:0] mBank = '0;
  logic              mCarry = 1'b0;
  logic              mOvf = 1'b0;
  logic              mUdf = 1'b0;
  logic [ADDR_W+BANK_W:0] mStack [$];

  logic [ADDR_W+BANK_W+2:0] expQ [$];
  string tagQ [$];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic modelPush(input logic [ADDR_W-1:0] a, input logic [BANK_W-1:0] b,
                           input logic c);
    if (mStack.size() == DEPTH) begin
      mOvf = 1'b1;
      void'(mStack.pop_front());
    end
    mStack.push_back({a, b, c});
  endtask

  task automatic step(input logic [2:0] op, input logic [ADDR_W-1:0] tgt,
                      input logic intr, input logic [BANK_W-1:0] bnk, input logic cy,
                      input logic rn, input logic por, input string tag);
    logic [ADDR_W+BANK_W:0] fr;
    @(negedge clk);
    opCode = op; targetAddr = tgt; intEnter = intr; bankIn = bnk; carryIn = cy;
    rstN = rn; porFlag = por;
    if (!rn || por) begin
      mPc = '0; mStack.delete(); mOvf = 0; mUdf = 0; mBank = '0; mCarry = 0;
    end else if (intr) begin
      modelPush(mPc, bnk, cy);
      mPc = VEC;
    end else begin
      case (op)
        3'b001: mPc = mPc + ADDR_W'(2);
        3'b010: mPc = tgt;
        3'b011: begin modelPush(mPc + ADDR_W'(1), bnk, cy); mPc = tgt; end
        3'b100, 3'b101: begin
          if (mStack.size() == 0) begin
            mUdf = 1'b1;
            mPc  = mPc + ADDR_W'(1);
          end else begin
            fr  = mStack.pop_back();
            mPc = fr[ADDR_W+BANK_W:BANK_W+1];
            if (op == 3'b101) begin
              mBank  = fr[BANK_W:1];
              mCarry = fr[0];
            end
          end
        end
        default: mPc = mPc + ADDR_W'(1);
      endcase
    end
    expQ.push_back({mPc, mBank, mCarry, mOvf, mUdf});
    tagQ.push_back(tag);
  endtask

  // Monitor: compares one expected item per clock edge, 1 ns after it
  initial begin
    logic [ADDR_W+BANK_W+2:0] exp, act;
    string tg;
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() != 0) begin
        exp = expQ.pop_front();
        tg  = tagQ.pop_front();
        act = {pc, bankOut, carryOut, stackOverflow, stackUnderflow};
        checks++;
        if (act !== exp) begin
          fails++;
          $display("FAIL %s {pc,bank,carry,ovf,udf} actual %h expected %h", tg, act, exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: external reset
    step(3'b011, 13'h0AA, 1'b1, 2'd3, 1'b1, 1'b0, 1'b0, "R1");
    step(3'b000, 13'h0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, "R1");
    // R2: step and unused codes
    step(3'b000, 13'h0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, "R2");
    step(3'b110, 13'h0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, "R2");
    step(3'b111, 13'h0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, "R2");
    // R3: skip
    step(3'b001, 13'h0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, "R3");
    // R4: jump to the top address, then wraps of step and skip (R2, R3)
    step(3'b010, 13'h1FFF, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, "R4");
    step(3'b000, 13'h0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, "R2");
    step(3'b010, 13'h1FFE, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, "R4");
    step(3'b001, 13'h0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, "R3");
    // R5, R6: nested calls, plain returns keep bank and carry
    step(3'b011, 13'h100, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0, "R5");
    step(3'b011, 13'h200, 1'b0, 2'd2, 1'b0, 1'b1, 1'b0, "R5");
    step(3'b100, 13'h0, 1'b0, 2'd3, 1'b1, 1'b1, 1'b0, "R6");
    step(3'b100, 13'h0, 1'b0, 2'd3, 1'b1, 1'b1, 1'b0, "R6");
    // R8: interrupt overrides a jump; R7: return from it restores bank and carry
    step(3'b010, 13'h0777, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, "R8");
    step(3'b010, 13'h0300, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, "R4");
    step(3'b101, 13'h0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, "R7");
    // R7 versus R6: interrupt inside a call, plain return keeps restored values
    step(3'b011, 13'h400, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, "R5");
    step(3'b000, 13'h0, 1'b1, 2'd1, 1'b0, 1'b1, 1'b0, "R8");
    step(3'b101, 13'h0, 1'b0, 2'd3, 1'b1, 1'b1, 1'b0, "R7");
    step(3'b100, 13'h0, 1'b0, 2'd3, 1'b1, 1'b1, 1'b0, "R6");
    // R9: eight-level nesting returns in LIFO order
    for (int i = 0; i < 8; i++)
      step(3'b011, ADDR_W'(13'h800 + 16 * i), 1'b0, 2'(i), 1'(i), 1'b1, 1'b0, "R9");
    for (int i = 0; i < 8; i++)
      step(3'b100, 13'h0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, "R9");
    // R11: pops from empty stack
    step(3'b100, 13'h0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, "R11");
    step(3'b101, 13'h0, 1'b0, 2'd2, 1'b1, 1'b1, 1'b0, "R11");
    // R12: underflow flag holds
    step(3'b000, 13'h0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, "R12");
    // R1: power-on indication clears everything
    step(3'b000, 13'h0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, "R1");
    // R10: nine pushes (last one an interrupt) overflow and drop the oldest
    for (int i = 0; i < 8; i++)
      step(3'b011, ADDR_W'(13'h1000 + 32 * i), 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, "R10");
    step(3'b000, 13'h0, 1'b1, 2'd3, 1'b1, 1'b1, 1'b0, "R10");
    step(3'b101, 13'h0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, "R10");
    for (int i = 0; i < 7; i++)
      step(3'b100, 13'h0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, "R10");
    step(3'b100, 13'h0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, "R11");
    // R12: both flags hold across further activity
    step(3'b010, 13'h0055, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, "R12");
    step(3'b001, 13'h0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, "R12");
    // R1: external reset clears flags again
    step(3'b000, 13'h0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, "R1");
    step(3'b000, 13'h0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, "R2");
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule